// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. The host sets an enable level and requests a conversion with a start strobe. The block can then run an acquisition window of a selectable number of conversion-clock ticks. After that it opens the sample/hold switch and resolves the result one bit per tick, most significant bit first. It does this by presenting a trial code to an external DAC and reading back a single comparator bit. The tick input is a one-cycle pulse that a divider outside the block provides. The analog parts and channel selection are outside the block.

When a conversion finishes, the result register is loaded, the busy indication drops, a sticky done flag rises and the sample/hold switch closes again. The host can cancel a running conversion, and the previous result then survives. A fixed two-tick recovery gap follows every conversion, whether it completed or was cancelled. A compare-match event from a capture/compare unit can also start a conversion. Whenever the unit's mode field selects that use, the event pulses a timer-reset output, whether or not the converter is enabled.

Top module: `adc_sar_seq`

## Requirements
- R1: After synchronous reset, busy, doneFlag, timerReset and startDropped are 0, result is 0 and sampleConnect is 1.
- R2: With convEnable high and acqCode 3'b000, startSet raises busy on the next cycle. The conversion uses exactly 11 tadTick pulses, and busy falls right after the 11th.
- R3: acqCode selects the number of acquisition ticks placed before conversion: 0,2,4,6,8,12,16,20 for codes 0 to 7. sampleConnect stays 1 through acquisition and goes to 0 on the first conversion tick.
- R4: dacCode is the trial word. The first trial is 10'h200. Bits are decided from bit 9 down to bit 0, one per tick. A trial bit is kept when cmpIn is 1, and the next lower bit is then tried.
- R5: On the final conversion tick, result takes the resolved word, busy clears, doneFlag sets and sampleConnect returns to 1.
- R6: startClear while busy cancels the conversion. busy clears, sampleConnect returns to 1, and result and doneFlag are left unchanged.
- R7: After a completion or a cancel, the block ignores start requests until 2 tadTick pulses have passed. A request made inside this gap leaves busy low and makes startDropped 1 for one cycle.
- R8: ccpMatch counts as a trigger only when ccpMode equals 4'b1011. With convEnable high, a trigger starts a conversion just as startSet does.
- R9: Each accepted trigger makes timerReset 1 for exactly the following cycle, whatever the state of convEnable. With convEnable low, the trigger leaves busy low.
- R10: resWrEn loads resWrData into result when busy is low. While busy is high, resWrEn has no effect.
- R11: doneFlag stays set until a doneClr strobe. If a completion and a doneClr fall in the same cycle, doneFlag ends up set.
- R12: startSet with convEnable low has no effect, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| convEnable | input | 1 | Converter enable level |
| startSet | input | 1 | Host start request strobe |
| startClear | input | 1 | Host cancel strobe |
| acqCode | input | 3 | Acquisition length code |
| tadTick | input | 1 | One-cycle conversion clock tick |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above dacCode |
| ccpMode | input | 4 | Capture/compare unit mode field |
| ccpMatch | input | 1 | Capture/compare match event |
| resWrEn | input | 1 | Host write strobe for the result register |
| resWrData | input | 10 | Host write data |
| doneClr | input | 1 | Clear strobe for doneFlag |
| busy | output | 1 | Start/busy indication |
| sampleConnect | output | 1 | Sample/hold switch, 1 = connected to the input |
| dacCode | output | 10 | Trial word sent to the DAC |
| result | output | 10 | Result register |
| doneFlag | output | 1 | Sticky completion flag |
| timerReset | output | 1 | One-cycle reset pulse to an external timer |
| startDropped | output | 1 | One-cycle pulse for a request refused during recovery |

## Verification
The assertions check the following on every cycle:
- an open sample/hold switch only while busy;
- a completion always leaves doneFlag set;
- a cancel always leaves the result stable;
- a dropped request never coincides with busy;
- a qualified trigger always produces the timer pulse;
- a disabled, idle converter never becomes busy.

Tick-exact conversion lengths for every acquisition code, the correct search value for a modelled analog level, the two-tick recovery window, and the ordering of clear against completion are shown only by the bench's directed and seeded random scenarios.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_RECOV = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sarInit;
    logic sarStep;
    logic resLoad;
  } dpStrobe_t;

  localparam int unsigned ACQ_MAX = 20;

  // acquisition length in ticks for each code
  function automatic logic [4:0] acqTadCount(input logic [2:0] code);
    logic [4:0] n;
    case (code)
      3'd0:    n = 5'd0;
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd4;
      3'd3:    n = 5'd6;
      3'd4:    n = 5'd8;
      3'd5:    n = 5'd12;
      3'd6:    n = 5'd16;
      default: n = 5'd20;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned RECOV_TADS = 2,
  parameter logic [3:0]  TRIG_MODE  = 4'b1011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       convEnable,
  input  logic       startSet,
  input  logic       startClear,
  input  logic [2:0] acqCode,
  input  logic       tadTick,
  input  logic [3:0] ccpMode,
  input  logic       ccpMatch,
  input  logic       doneClr,
  output logic       busy,
  output logic       sampleConnect,
  output logic       doneFlag,
  output logic       timerReset,
  output logic       startDropped,
  output dpStrobe_t  strobe
);

  localparam int unsigned MAX_A = (ACQ_MAX > DATA_W) ? ACQ_MAX : DATA_W;
  localparam int unsigned MAX_V = (MAX_A > RECOV_TADS) ? MAX_A : RECOV_TADS;
  localparam int unsigned CNT_W = $clog2(MAX_V + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       acqN;
  logic             trigHit;
  logic             startReq;
  logic             lastCnt;
  logic             lastBit;

  assign acqN     = acqTadCount(acqCode);
  assign trigHit  = ccpMatch && (ccpMode == TRIG_MODE);
  assign startReq = convEnable && (startSet || trigHit);
  assign lastCnt  = (cnt == '0);
  assign lastBit  = (cnt == CNT_W'(DATA_W));

  always_comb begin
    strobe.sarInit = 1'b0;
    strobe.sarStep = 1'b0;
    strobe.resLoad = 1'b0;
    case (state)
      ST_IDLE: strobe.sarInit = startReq && (acqN == 5'd0);
      ST_ACQ:  strobe.sarInit = !startClear && tadTick && lastCnt;
      ST_CONV: begin
        strobe.sarStep = !startClear && tadTick && !lastCnt;
        strobe.resLoad = !startClear && tadTick && lastBit;
      end
      default: ;
    endcase
  end

  assign busy          = (state == ST_ACQ) || (state == ST_CONV);
  assign sampleConnect = !((state == ST_CONV) && !lastCnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      doneFlag     <= 1'b0;
      timerReset   <= 1'b0;
      startDropped <= 1'b0;
    end else begin
      timerReset   <= trigHit;
      startDropped <= startReq && (state == ST_RECOV);
      if (strobe.resLoad) doneFlag <= 1'b1;
      else if (doneClr)   doneFlag <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (acqN == 5'd0) begin
              state <= ST_CONV;
              cnt   <= '0;
            end else begin
              state <= ST_ACQ;
              cnt   <= CNT_W'(acqN) - CNT_W'(1);
            end
          end
        end
        ST_ACQ: begin
          if (startClear) begin
            state <= ST_RECOV;
            cnt   <= CNT_W'(RECOV_TADS - 1);
          end else if (tadTick) begin
            if (lastCnt) begin
              state <= ST_CONV;
              cnt   <= '0;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        ST_CONV: begin
          if (startClear) begin
            state <= ST_RECOV;
            cnt   <= CNT_W'(RECOV_TADS - 1);
          end else if (tadTick) begin
            if (lastBit) begin
              state <= ST_RECOV;
              cnt   <= CNT_W'(RECOV_TADS - 1);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: begin
          if (tadTick) begin
            if (lastCnt) state <= ST_IDLE;
            else         cnt   <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic              cmpIn,
  input  logic              resWrEn,
  input  logic [DATA_W-1:0] resWrData,
  input  logic              busy,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] nextSar;

  // keep the trial bit when the comparator says input >= trial
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_bit
      assign nextSar[g] = sarReg[g] | (maskReg[g] & cmpIn);
    end
  endgenerate

  assign dacCode = sarReg | maskReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sarReg  <= '0;
      maskReg <= '0;
      result  <= '0;
    end else begin
      if (strobe.sarInit) begin
        sarReg  <= '0;
        maskReg <= TOP_BIT;
      end else if (strobe.sarStep) begin
        sarReg  <= nextSar;
        maskReg <= maskReg >> 1;
      end
      if (strobe.resLoad)        result <= nextSar;
      else if (resWrEn && !busy) result <= resWrData;
    end
  end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned RECOV_TADS = 2,
  parameter logic [3:0]  TRIG_MODE  = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convEnable,
  input  logic              startSet,
  input  logic              startClear,
  input  logic [2:0]        acqCode,
  input  logic              tadTick,
  input  logic              cmpIn,
  input  logic [3:0]        ccpMode,
  input  logic              ccpMatch,
  input  logic              resWrEn,
  input  logic [DATA_W-1:0] resWrData,
  input  logic              doneClr,
  output logic              busy,
  output logic              sampleConnect,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] result,
  output logic              doneFlag,
  output logic              timerReset,
  output logic              startDropped
);

  dpStrobe_t strobe;

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .RECOV_TADS(RECOV_TADS), .TRIG_MODE(TRIG_MODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .convEnable(convEnable), .startSet(startSet),
    .startClear(startClear), .acqCode(acqCode), .tadTick(tadTick),
    .ccpMode(ccpMode), .ccpMatch(ccpMatch), .doneClr(doneClr),
    .busy(busy), .sampleConnect(sampleConnect), .doneFlag(doneFlag),
    .timerReset(timerReset), .startDropped(startDropped), .strobe(strobe)
  );

  adc_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .cmpIn(cmpIn),
    .resWrEn(resWrEn), .resWrData(resWrData), .busy(busy),
    .dacCode(dacCode), .result(result)
  );

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int unsigned DATA_W    = 10,
  parameter logic [3:0]  TRIG_MODE = 4'b1011
) (
  input logic              clk,
  input logic              rst,
  input logic              convEnable,
  input logic              startClear,
  input logic [3:0]        ccpMode,
  input logic              ccpMatch,
  input logic              busy,
  input logic              sampleConnect,
  input logic [DATA_W-1:0] result,
  input logic              doneFlag,
  input logic              timerReset,
  input logic              startDropped
);

  a_r3_open_only_busy: assert property (@(posedge clk) disable iff (rst)
    !sampleConnect |-> busy);

  a_r5_done_on_finish: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(startClear)) |-> doneFlag);

  a_r6_abort_keeps_result: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(startClear)) |-> $stable(result));

  a_r7_drop_not_busy: assert property (@(posedge clk) disable iff (rst)
    startDropped |-> !busy);

  a_r9_timer_pulse: assert property (@(posedge clk) disable iff (rst)
    (ccpMatch && ccpMode == TRIG_MODE) |=> timerReset);

  a_r11_done_rises_on_finish: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $fell(busy));

  a_r12_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (!convEnable && !busy) |=> !busy);

endmodule

bind adc_sar_seq adc_sar_seq_chk #(.DATA_W(DATA_W), .TRIG_MODE(TRIG_MODE)) u_chk (.*);

// File: tb/adc_sar_seq_tb.sv
module adc_sar_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       convEnable = 1'b0;
  logic       startSet = 1'b0;
  logic       startClear = 1'b0;
  logic [2:0] acqCode = 3'd0;
  logic       tadTick = 1'b0;
  logic       cmpIn;
  logic [3:0] ccpMode = 4'd0;
  logic       ccpMatch = 1'b0;
  logic       resWrEn = 1'b0;
  logic [9:0] resWrData = 10'd0;
  logic       doneClr = 1'b0;
  logic       busy, sampleConnect, doneFlag, timerReset, startDropped;
  logic [9:0] dacCode, result;
  logic [9:0] vAnalog = 10'd0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  // comparator model
  assign cmpIn = (vAnalog >= dacCode);

  adc_sar_seq u_dut (
    .clk(clk), .rst(rst), .convEnable(convEnable), .startSet(startSet),
    .startClear(startClear), .acqCode(acqCode), .tadTick(tadTick),
    .cmpIn(cmpIn), .ccpMode(ccpMode), .ccpMatch(ccpMatch),
    .resWrEn(resWrEn), .resWrData(resWrData), .doneClr(doneClr),
    .busy(busy), .sampleConnect(sampleConnect), .dacCode(dacCode),
    .result(result), .doneFlag(doneFlag), .timerReset(timerReset),
    .startDropped(startDropped)
  );

  function automatic int acqTicks(input logic [2:0] c);
    case (c)
      3'd0: return 0;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
      3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulseTick();
    tadTick = 1'b1;
    @(negedge clk);
    tadTick = 1'b0;
  endtask

  task automatic runConv(input logic [2:0] code, input logic [9:0] val, input bit clrOnLast);
    int n;
    vAnalog = val;
    acqCode = code;
    startSet = 1'b1;
    cyc();
    startSet = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    n = acqTicks(code);
    for (int i = 0; i < n; i++) pulseTick();
    chk(sampleConnect == 1'b1 && busy, "R3 connected through acquisition", sampleConnect, 1);
    pulseTick();
    chk(sampleConnect == 1'b0, "R3 open on first conversion tick", sampleConnect, 0);
    chk(dacCode == 10'h200, "R4 first trial", dacCode, 10'h200);
    pulseTick();
    chk(dacCode == ((val & 10'h200) | 10'h100), "R4 second trial", dacCode,
        (val & 10'h200) | 10'h100);
    for (int i = 0; i < 8; i++) pulseTick();
    chk(busy == 1'b1, "R2 busy before 11th tick", busy, 1);
    doneClr = clrOnLast;
    pulseTick();
    doneClr = 1'b0;
    chk(busy == 1'b0, "R2 idle after 11th tick", busy, 0);
    chk(result == val, "R5 result", result, val);
    chk(doneFlag == 1'b1, "R5 R11 done set", doneFlag, 1);
    chk(sampleConnect == 1'b1, "R5 reconnected", sampleConnect, 1);
  endtask

  task automatic recover();
    pulseTick();
    pulseTick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] keep;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1
    chk(!busy && !doneFlag && !timerReset && !startDropped, "R1 flags", busy, 0);
    chk(result == 10'd0 && sampleConnect, "R1 result/switch", result, 0);

    // R12: disabled start ignored
    startSet = 1'b1; cyc(); startSet = 1'b0; cyc();
    chk(busy == 1'b0, "R12 disabled start", busy, 0);

    convEnable = 1'b1;
    // R10 host write when idle
    resWrData = 10'h155; resWrEn = 1'b1; cyc(); resWrEn = 1'b0;
    chk(result == 10'h155, "R10 idle write", result, 10'h155);

    // directed corner values
    runConv(3'd0, 10'h000, 1'b0); recover();
    runConv(3'd2, 10'h3FF, 1'b0); recover();
    // R11 sticky and same-cycle clear vs completion
    chk(doneFlag == 1'b1, "R11 sticky", doneFlag, 1);
    runConv(3'd7, 10'h2A5, 1'b1);
    chk(doneFlag == 1'b1, "R11 completion wins", doneFlag, 1);

    // R7 recovery drop
    startSet = 1'b1; cyc(); startSet = 1'b0;
    chk(startDropped == 1'b1 && !busy, "R7 drop in gap", startDropped, 1);
    cyc();
    chk(startDropped == 1'b0, "R7 drop pulse one cycle", startDropped, 0);
    pulseTick();
    startSet = 1'b1; cyc(); startSet = 1'b0;
    chk(busy == 1'b0, "R7 still in gap", busy, 0);
    pulseTick();
    doneClr = 1'b1; cyc(); doneClr = 1'b0;
    chk(doneFlag == 1'b0, "R11 clear", doneFlag, 0);

    // R6 abort during conversion, R10 write while busy ignored
    keep = result;
    vAnalog = 10'h0F0; acqCode = 3'd1;
    startSet = 1'b1; cyc(); startSet = 1'b0;
    chk(busy == 1'b1, "R7 start after gap", busy, 1);
    repeat (5) pulseTick();
    resWrData = 10'h001; resWrEn = 1'b1; cyc(); resWrEn = 1'b0;
    chk(result == keep, "R10 busy write ignored", result, keep);
    startClear = 1'b1; cyc(); startClear = 1'b0;
    chk(busy == 1'b0 && sampleConnect, "R6 abort idle", busy, 0);
    chk(result == keep, "R6 result kept", result, keep);
    chk(doneFlag == 1'b0, "R6 no done", doneFlag, 0);
    startSet = 1'b1; cyc(); startSet = 1'b0;
    chk(startDropped == 1'b1, "R7 gap after abort", startDropped, 1);
    recover();

    // R8/R9 triggers
    convEnable = 1'b0; ccpMode = 4'b1011; ccpMatch = 1'b1; cyc(); ccpMatch = 1'b0;
    chk(timerReset == 1'b1 && !busy, "R9 disabled trigger", timerReset, 1);
    cyc();
    chk(timerReset == 1'b0, "R9 pulse one cycle", timerReset, 0);
    convEnable = 1'b1; ccpMode = 4'b1010; ccpMatch = 1'b1; cyc(); ccpMatch = 1'b0;
    chk(!timerReset && !busy, "R8 wrong mode ignored", timerReset, 0);
    ccpMode = 4'b1011; vAnalog = 10'h1C3; acqCode = 3'd0;
    ccpMatch = 1'b1; cyc(); ccpMatch = 1'b0;
    chk(busy && timerReset, "R8 trigger starts", busy, 1);
    repeat (11) pulseTick();
    chk(result == 10'h1C3 && !busy, "R8 triggered result", result, 10'h1C3);
    recover();

    // random conversions
    for (int k = 0; k < 24; k++) begin
      logic [2:0] c;
      logic [9:0] v;
      c = 3'($urandom % 8);
      v = 10'($urandom % 1024);
      doneClr = 1'b1; cyc(); doneClr = 1'b0;
      runConv(c, v, 1'b0);
      recover();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule